// File: doc/BRIEF.md
# Touch Panel Driver Switch Controller

This block decides which panel drivers of a four-wire resistive touch screen are energised while a measurement runs. It captures the selected measurement channel, the reference mode and the power-down mode when the acquisition phase starts.

From that capture it enables one driver pair: the Y pair when the X+ plate is sensed, and the X pair when the Y+ plate is sensed. It then turns the pair off again at the point each mode calls for. It also controls the Y- low-side switch that is used for touch detection between measurements.

The conversion sequencer around this block supplies single-cycle phase pulses (acquisition start, conversion start, end of conversion). It also supplies the live control-word fields and the active-low chip select. All three enables are registered and change on the clock edge after the pulse that causes them.

Top module: `touch_drv_ctrl`

## Requirements
- R1: With the chip selected, an acquisition pulse with channel code 3'b001 turns on the Y driver pair (and only it) at the next clock edge.
- R2: With the chip selected, an acquisition pulse with channel code 3'b101 turns on the X driver pair (and only it) at the next clock edge.
- R3: An acquisition pulse with any channel code other than 3'b001 or 3'b101 leaves both driver pairs off.
- R4: If the reference mode captured at acquisition is single-ended (`single_ended_i` = 1), a conversion-start pulse turns the driver pair off at the next clock edge.
- R5: If the captured reference mode is ratiometric (`single_ended_i` = 0), the driver pair stays on through the conversion. At an end-of-conversion pulse with a captured power-down code other than 2'b11, it turns off at the next clock edge.
- R6: At an end-of-conversion pulse with a captured power-down code of 2'b00, 2'b01 or 2'b10, the Y- switch turns on at the next clock edge. It stays on until the next acquisition pulse or until the chip is deselected.
- R7: With captured power-down code 2'b11 (no power-down) in ratiometric mode, the driver pair stays on after end of conversion. It turns off at the clock edge after the live channel, reference mode or power-down field first differs from the captured value.
- R8: While `cs_ni` is high, all three enables are off from the next clock edge, and acquisition pulses are ignored.
- R9: All enables are off during reset. At most one of the X pair, Y pair and Y- switch enables is ever active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| chan_i | input | 3 | Live channel field of the control word |
| single_ended_i | input | 1 | Live reference mode: 1 single-ended, 0 ratiometric |
| pd_i | input | 2 | Live power-down field; 2'b11 means no power-down |
| acq_i | input | 1 | Pulse: acquisition phase starts, settings are captured |
| conv_i | input | 1 | Pulse: conversion phase starts |
| eoc_i | input | 1 | Pulse: conversion has ended |
| x_drv_en_o | output | 1 | X driver pair enable |
| y_drv_en_o | output | 1 | Y driver pair enable |
| yneg_en_o | output | 1 | Y- low-side switch enable |

## Verification
On every cycle the assertions check the channel-to-driver mapping at acquisition, the switch-off on conversion start in single-ended mode, and the switch-off plus Y- enable at end of conversion. They also check that the enables are mutually exclusive, that deselection clears everything, and that a held driver pair stays put while the settings are stable. The bench's scenarios are needed to show complete sequences. These cover a held pair surviving several conversions and then dropping when each of the three fields is altered, Y- persisting until the next acquisition, and pulses that arrive while deselected being ignored.

// File: rtl/touch_drv_pkg.sv
package touch_drv_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_X    = 2'd1,
    DRV_Y    = 2'd2
  } drv_sel_e;
endpackage

// File: rtl/tdc_chan_decode.sv
module tdc_chan_decode
  import touch_drv_pkg::*;
#(
  parameter int unsigned CHAN_W = 3,
  parameter logic [CHAN_W-1:0] XP_CHAN = 3'b001,
  parameter logic [CHAN_W-1:0] YP_CHAN = 3'b101
) (
  input  logic [CHAN_W-1:0] chan_i,
  output drv_sel_e          sel_o
);
  // sensing one plate means driving the other
  always_comb begin
    if (chan_i == XP_CHAN)      sel_o = DRV_Y;
    else if (chan_i == YP_CHAN) sel_o = DRV_X;
    else                        sel_o = DRV_NONE;
  end
endmodule

// File: rtl/tdc_setting_track.sv
module tdc_setting_track #(
  parameter int unsigned CHAN_W = 3,
  parameter int unsigned PD_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              single_ended_i,
  input  logic [PD_W-1:0]   pd_i,
  output logic              se_q_o,
  output logic [PD_W-1:0]   pd_q_o,
  output logic              changed_o
);
  localparam int unsigned SET_W = CHAN_W + 1 + PD_W;

  logic [SET_W-1:0] live_set, set_q;

  assign live_set = {chan_i, single_ended_i, pd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        set_q <= '0;
    else if (capture_i) set_q <= live_set;
  end

  assign se_q_o    = set_q[PD_W];
  assign pd_q_o    = set_q[PD_W-1:0];
  assign changed_o = (live_set != set_q);
endmodule

// File: rtl/tdc_sequencer.sv
module tdc_sequencer
  import touch_drv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cs_ni,
  input  logic     acq_i,
  input  logic     conv_i,
  input  logic     eoc_i,
  input  drv_sel_e sel_i,
  input  logic     changed_i,
  input  logic     se_q_i,
  input  logic     pd_hold_i,
  output drv_sel_e drv_o,
  output logic     yneg_o
);
  drv_sel_e drv_q, drv_d;
  logic     yneg_q, yneg_d;
  logic     eoc_release;

  assign eoc_release = eoc_i && !pd_hold_i;

  always_comb begin
    drv_d  = drv_q;
    yneg_d = yneg_q;
    if (cs_ni) begin
      drv_d  = DRV_NONE;
      yneg_d = 1'b0;
    end else if (acq_i) begin
      drv_d  = sel_i;
      yneg_d = 1'b0;
    end else begin
      if (changed_i || (conv_i && se_q_i) || eoc_release) drv_d = DRV_NONE;
      if (eoc_release) yneg_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q  <= DRV_NONE;
      yneg_q <= 1'b0;
    end else begin
      drv_q  <= drv_d;
      yneg_q <= yneg_d;
    end
  end

  assign drv_o  = drv_q;
  assign yneg_o = yneg_q;
endmodule

// File: rtl/touch_drv_ctrl.sv
module touch_drv_ctrl
  import touch_drv_pkg::*;
#(
  parameter int unsigned CHAN_W = 3,
  parameter int unsigned PD_W   = 2,
  parameter logic [CHAN_W-1:0] XP_CHAN = 3'b001,
  parameter logic [CHAN_W-1:0] YP_CHAN = 3'b101,
  parameter logic [PD_W-1:0]   PD_HOLD = 2'b11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              single_ended_i,
  input  logic [PD_W-1:0]   pd_i,
  input  logic              acq_i,
  input  logic              conv_i,
  input  logic              eoc_i,
  output logic              x_drv_en_o,
  output logic              y_drv_en_o,
  output logic              yneg_en_o
);
  drv_sel_e          sel, drv;
  logic              se_q, changed;
  logic [PD_W-1:0]   pd_q;

  tdc_chan_decode #(.CHAN_W(CHAN_W), .XP_CHAN(XP_CHAN), .YP_CHAN(YP_CHAN)) u_dec (
    .chan_i (chan_i),
    .sel_o  (sel)
  );

  tdc_setting_track #(.CHAN_W(CHAN_W), .PD_W(PD_W)) u_trk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .capture_i      (acq_i && !cs_ni),
    .chan_i         (chan_i),
    .single_ended_i (single_ended_i),
    .pd_i           (pd_i),
    .se_q_o         (se_q),
    .pd_q_o         (pd_q),
    .changed_o      (changed)
  );

  tdc_sequencer u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .acq_i     (acq_i),
    .conv_i    (conv_i),
    .eoc_i     (eoc_i),
    .sel_i     (sel),
    .changed_i (changed),
    .se_q_i    (se_q),
    .pd_hold_i (pd_q == PD_HOLD),
    .drv_o     (drv),
    .yneg_o    (yneg_en_o)
  );

  assign x_drv_en_o = (drv == DRV_X);
  assign y_drv_en_o = (drv == DRV_Y);
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
  parameter int unsigned CHAN_W = 3,
  parameter int unsigned PD_W   = 2,
  parameter logic [CHAN_W-1:0] XP_CHAN = 3'b001,
  parameter logic [CHAN_W-1:0] YP_CHAN = 3'b101,
  parameter logic [PD_W-1:0]   PD_HOLD = 2'b11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic [CHAN_W-1:0] chan_i,
  input logic              single_ended_i,
  input logic [PD_W-1:0]   pd_i,
  input logic              acq_i,
  input logic              conv_i,
  input logic              eoc_i,
  input logic              x_drv_en_o,
  input logic              y_drv_en_o,
  input logic              yneg_en_o
);
  logic [PD_W-1:0] pd_seen;
  logic            sel_act;

  assign sel_act = !cs_ni && !acq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pd_seen <= '0;
    else if (!cs_ni && acq_i) pd_seen <= pd_i;
  end

  p_ypair_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && acq_i && chan_i == XP_CHAN) |=> (y_drv_en_o && !x_drv_en_o));
  p_xpair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && acq_i && chan_i == YP_CHAN) |=> (x_drv_en_o && !y_drv_en_o));
  p_nopair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && acq_i && chan_i != XP_CHAN && chan_i != YP_CHAN) |=> !(x_drv_en_o || y_drv_en_o));
  p_se_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_act && conv_i && single_ended_i) |=> !(x_drv_en_o || y_drv_en_o));
  p_eoc_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_act && eoc_i && pd_seen != PD_HOLD) |=> (!x_drv_en_o && !y_drv_en_o && yneg_en_o));
  p_yneg_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_act && yneg_en_o) |=> yneg_en_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_act && !conv_i && !eoc_i && (x_drv_en_o || y_drv_en_o) && $stable(chan_i)
     && $stable(single_ended_i) && $stable(pd_i)) |=> ($stable(x_drv_en_o) && $stable(y_drv_en_o)));
  p_desel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !(x_drv_en_o || y_drv_en_o || yneg_en_o));
  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({x_drv_en_o, y_drv_en_o, yneg_en_o}));
endmodule

bind touch_drv_ctrl tdc_checker #(
  .CHAN_W(CHAN_W), .PD_W(PD_W), .XP_CHAN(XP_CHAN), .YP_CHAN(YP_CHAN), .PD_HOLD(PD_HOLD)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cs_ni          (cs_ni),
  .chan_i         (chan_i),
  .single_ended_i (single_ended_i),
  .pd_i           (pd_i),
  .acq_i          (acq_i),
  .conv_i         (conv_i),
  .eoc_i          (eoc_i),
  .x_drv_en_o     (x_drv_en_o),
  .y_drv_en_o     (y_drv_en_o),
  .yneg_en_o      (yneg_en_o)
);

// File: tb/touch_drv_ctrl_tb.sv
`timescale 1ns/1ps
module touch_drv_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic [2:0] chan = 3'd0;
  logic       se = 1'b0;
  logic [1:0] pd = 2'd0;
  logic       acq = 1'b0, conv = 1'b0, eoc = 1'b0;
  logic       x_en, y_en, yn_en;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R9";

  // reference model state: 0 none, 1 X pair, 2 Y pair
  int       m_drv = 0;
  bit       m_yn = 0;
  bit [2:0] c_chan = 0;
  bit       c_se = 0;
  bit [1:0] c_pd = 0;

  always #2.5 clk = ~clk;

  touch_drv_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .chan_i(chan), .single_ended_i(se),
    .pd_i(pd), .acq_i(acq), .conv_i(conv), .eoc_i(eoc),
    .x_drv_en_o(x_en), .y_drv_en_o(y_en), .yneg_en_o(yn_en)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_drv <= 0; m_yn <= 0; c_chan <= 0; c_se <= 0; c_pd <= 0;
    end else if (cs_n) begin
      m_drv <= 0; m_yn <= 0;
    end else if (acq) begin
      m_drv <= (chan == 3'b001) ? 2 : (chan == 3'b101) ? 1 : 0;
      m_yn <= 0;
      c_chan <= chan; c_se <= se; c_pd <= pd;
    end else begin
      if (chan != c_chan || se != c_se || pd != c_pd) m_drv <= 0;
      else if (conv && c_se) m_drv <= 0;
      else if (eoc && c_pd != 2'b11) m_drv <= 0;
      if (eoc && c_pd != 2'b11) m_yn <= 1;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    chk(x_en, m_drv == 1, cur_req, "x_drv_en");
    chk(y_en, m_drv == 2, cur_req, "y_drv_en");
    chk(yn_en, m_yn, cur_req, "yneg_en");
  endtask

  task automatic pulse_acq(); acq = 1; step(); acq = 0; endtask
  task automatic pulse_conv(); conv = 1; step(); conv = 0; endtask
  task automatic pulse_eoc(); eoc = 1; step(); eoc = 0; endtask

  // acquisition, 3 settle cycles, conversion of 12 cycles, end of conversion
  task automatic frame(input bit [2:0] c, input bit s, input bit [1:0] p);
    chan = c; se = s; pd = p;
    pulse_acq();
    repeat (2) step();
    pulse_conv();
    repeat (11) step();
    pulse_eoc();
    repeat (3) step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cur_req = "R9";
    #1;
    chk(x_en, 1'b0, "R9", "reset x");
    chk(y_en, 1'b0, "R9", "reset y");
    chk(yn_en, 1'b0, "R9", "reset yneg");
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    step();
    cs_n = 0;
    step();

    cur_req = "R1";
    chan = 3'b001; se = 0; pd = 2'b00;
    pulse_acq();
    chk(y_en, 1'b1, "R1", "Y pair on after acq");
    chk(x_en, 1'b0, "R1", "X pair off");

    cur_req = "R5";
    repeat (2) step();
    pulse_conv();
    chk(y_en, 1'b1, "R5", "ratiometric holds through conversion");
    repeat (11) step();
    pulse_eoc();
    chk(y_en, 1'b0, "R5", "pair off at eoc");
    cur_req = "R6";
    chk(yn_en, 1'b1, "R6", "Y- on at eoc");
    repeat (5) step();
    chk(yn_en, 1'b1, "R6", "Y- stays on");

    cur_req = "R2";
    chan = 3'b101; pd = 2'b10;
    pulse_acq();
    chk(x_en, 1'b1, "R2", "X pair on after acq");
    chk(yn_en, 1'b0, "R6", "Y- off at new acq");

    cur_req = "R4";
    se = 1;
    frame(3'b101, 1'b1, 2'b01);
    frame(3'b001, 1'b1, 2'b11);
    chan = 3'b001; se = 1; pd = 2'b00;
    pulse_acq();
    pulse_conv();
    chk(y_en, 1'b0, "R4", "single-ended off at conversion start");

    cur_req = "R3";
    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 5) continue;
      chan = c[2:0]; se = 0; pd = 2'b11;
      pulse_acq();
      chk(x_en | y_en, 1'b0, "R3", "no pair for other channel");
      step();
    end

    cur_req = "R7";
    frame(3'b101, 1'b0, 2'b11);
    chk(x_en, 1'b1, "R7", "held after eoc");
    chk(yn_en, 1'b0, "R7", "no Y- in hold mode");
    repeat (10) step();
    chan = 3'b100; step();
    chk(x_en, 1'b0, "R7", "off after channel change");
    frame(3'b001, 1'b0, 2'b11);
    se = 1; step();
    chk(y_en, 1'b0, "R7", "off after reference change");
    frame(3'b001, 1'b0, 2'b11);
    pd = 2'b01; step();
    chk(y_en, 1'b0, "R7", "off after power-down change");

    cur_req = "R8";
    frame(3'b101, 1'b0, 2'b11);
    cs_n = 1; step();
    chk(x_en, 1'b0, "R8", "deselect clears pair");
    chan = 3'b001; pd = 2'b11; se = 0;
    pulse_acq();
    chk(y_en, 1'b0, "R8", "acq ignored while deselected");
    cs_n = 0;
    frame(3'b001, 1'b0, 2'b00);
    chk(yn_en, 1'b1, "R8", "Y- on before deselect");
    cs_n = 1; step();
    chk(yn_en, 1'b0, "R8", "deselect clears Y-");
    cs_n = 0;

    cur_req = "R9";
    rst_n = 0; #1;
    chk(x_en | y_en | yn_en, 1'b0, "R9", "async reset clears");
    step(); rst_n = 1; step();

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule